// File: doc/BRIEF.md
# Line Receive Output Formatter

This block sits on the system side of a T1/E1 line receiver. It takes the recovered line clock and the two rail pulse signals (positive and negative marks). It presents them to the system in one of four formats, chosen by a two-bit format field:

- single-rail decoded data with a code-violation flag, using either plain bipolar (AMI) decoding or zero-substitution removal;
- dual-rail data;
- a raw pass-through, in which the output clock is the XOR of the two rails.

The recovered clock, the rails and the loss-of-signal indication are sampled by a fast system clock. The output clock is rebuilt from the sampled recovered clock. All output data is updated on the active edge of the recovered clock, and an edge-select input chooses that edge. A polarity-invert control sets the active level of the data pins. A power-down input forces every output low. The line-standard input selects the substitution code: B8ZS on T1 lines, HDB3 on E1 lines.

An output state machine has three states:

- `ST_IDLE`: after reset, all outputs low.
- `ST_RUN`: the outputs are live.
- `ST_OFF`: powered down, all outputs low.

It moves between them only on active edges:

- `ST_IDLE` to `ST_RUN` when power-down is low at the edge.
- `ST_IDLE` to `ST_OFF` when power-down is high at the edge.
- `ST_RUN` to `ST_OFF` when power-down is high at the edge.
- `ST_OFF` to `ST_RUN` when power-down is low at the edge.

The format, invert and power-down controls are sampled only on active edges.

Top module: `rx_line_formatter`

## Requirements
- R1: After reset, and until the first active edge of the recovered clock, `rclk_out`, `rd_p_out`, `rd_n_out` and `los_out` are all 0.
- R2: `edge_sel`=0 makes the rising edge of `rclk_in` the active edge, and `edge_sel`=1 makes it the falling edge. In the decoded formats, data outputs change only one system cycle after an active edge, which is the same cycle in which `rclk_out` reproduces that edge.
- R3: `fmt_in` encodes the format as follows: 00 single-rail AMI, 01 single-rail with substitution removal, 10 dual-rail, 11 raw pass-through. A new value takes effect at the next active edge, and not before.
- R4: In single-rail formats, `rd_p_out` carries the decoded bit and `rd_n_out` the violation flag. Recovered-clock rising edges are numbered from 0 after reset, and the symbol sampled at rising edge k is symbol k. With that numbering, the output loaded at rising edge k is decoded bit k-9, and the output loaded at the falling edge after rising edge k is bit k-8. Bits before 0 read as 0.
- R5: A symbol is a mark when exactly one of `pos_in` and `neg_in` is 1, with polarity positive when `pos_in`=1. A mark decodes as 1. A mark with the same polarity as the previous mark raises the violation flag for that bit. The mark before the first one after reset counts as negative.
- R6: In format 01 with `e1_sel`=0, the group 0,0,0,V,B,0,V,B decodes as eight zeros with no violation. Here V has the polarity of the preceding mark and B the opposite.
- R7: In format 01 with `e1_sel`=1, two groups each decode as four zeros with no violation: 0,0,0,V, where V has the polarity of the preceding mark, and B,0,0,V, where B and V have the polarity opposite the preceding mark. After B,0,0,V, the preceding-mark polarity becomes that of V.
- R8: In format 10, `rd_p_out`/`rd_n_out` carry the sampled positive/negative rails. The output loaded at rising edge k shows symbol k-1, and the output loaded at the falling edge after it shows symbol k.
- R9: In format 11, at every system cycle `rd_p_out` and `rd_n_out` take the rail inputs of the cycle before, and `rclk_out` takes their XOR.
- R10: `inv_in`, sampled at active edges, inverts `rd_p_out` in every format and `rd_n_out` in formats 10 and 11. It never inverts the violation flag or `rclk_out`.
- R11: `pd_in` high at an active edge forces all four outputs to 0 from the next cycle. After `pd_in` is seen low at a later active edge, the outputs resume at that edge.
- R12: While running, `los_out` follows `los_in` with one system cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| rclk_in | input | 1 | Recovered line clock, sampled by `clk` |
| pos_in | input | 1 | Positive-rail pulse |
| neg_in | input | 1 | Negative-rail pulse |
| los_in | input | 1 | Loss-of-signal indication from the line side |
| fmt_in | input | 2 | Output format select |
| e1_sel | input | 1 | Line standard: 0 T1 (B8ZS), 1 E1 (HDB3) |
| edge_sel | input | 1 | Active edge: 0 rising, 1 falling |
| inv_in | input | 1 | Invert data outputs |
| pd_in | input | 1 | Receive power-down |
| rclk_out | output | 1 | System-side clock |
| rd_p_out | output | 1 | Data, or positive rail |
| rd_n_out | output | 1 | Violation flag, or negative rail |
| los_out | output | 1 | Loss-of-signal, gated by power-down |

## Verification
Some properties are checked on every cycle:

- outputs stay low in the idle state;
- decoded-format data holds steady between active edges;
- a power-down sampled at an edge clears every output;
- in pass-through, the clock output always equals the XOR of the previous rails;
- a raised violation flag always comes with an asserted mark.

Other behaviours only the scenarios can show. These are the exact bit latencies per edge choice, and the removal of B8ZS and HDB3 groups across a stream. They also include the deferral of a format change to the next edge, and the resumption after power-down.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_OFF  = 2'd2
    } fsm_t;

    localparam int          DEC_WIN   = 8;
    localparam int          HDB_LEN   = 4;
    localparam int          FMT_W     = 2;
    localparam logic [1:0]  FMT_AMI   = 2'b00;
    localparam logic [1:0]  FMT_SUB   = 2'b01;
    localparam logic [1:0]  FMT_DUAL  = 2'b10;
    localparam logic [1:0]  FMT_PASS  = 2'b11;

endpackage

// File: rtl/rxf_edge.sv
module rxf_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic rclk_in,
    input  logic pos_in,
    input  logic neg_in,
    input  logic edge_sel,
    output logic rise_stb,
    output logic act_stb,
    output logic rail_p,
    output logic rail_n
);
    logic rclk_q;
    logic fall_stb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rclk_q <= 1'b0;
            rail_p <= 1'b0;
            rail_n <= 1'b0;
        end else begin
            rclk_q <= rclk_in;
            if (rise_stb) begin
                rail_p <= pos_in;
                rail_n <= neg_in;
            end
        end
    end

    always_comb begin
        rise_stb = rclk_in & ~rclk_q;
        fall_stb = ~rclk_in & rclk_q;
        act_stb  = edge_sel ? fall_stb : rise_stb;
    end

endmodule

// File: rtl/rxf_decoder.sv
module rxf_decoder
    import rxf_pkg::*;
#(
    parameter int WIN  = DEC_WIN,
    parameter int HLEN = HDB_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic in_mark,
    input  logic in_pol,
    input  logic sub_en,
    input  logic e1_mode,
    output logic out_d,
    output logic out_cv
);
    localparam int T = WIN - 1;

    logic [WIN-1:0] mk;
    logic [WIN-1:0] pl;
    logic [WIN-1:0] mk_s;
    logic           lp;
    logic           hit_b8;
    logic           hit_h0;
    logic           hit_hb;

    always_comb begin
        hit_b8 = sub_en && !e1_mode
              && !mk[T] && !mk[T-1] && !mk[T-2]
              && mk[T-3] && (pl[T-3] == lp)
              && mk[T-4] && (pl[T-4] != lp)
              && !mk[T-5]
              && mk[T-6] && (pl[T-6] != lp)
              && mk[T-7] && (pl[T-7] == lp);
        hit_h0 = sub_en && e1_mode
              && !mk[T] && !mk[T-1] && !mk[T-2]
              && mk[T-HLEN+1] && (pl[T-HLEN+1] == lp);
        hit_hb = sub_en && e1_mode
              && mk[T] && (pl[T] != lp)
              && !mk[T-1] && !mk[T-2]
              && mk[T-HLEN+1] && (pl[T-HLEN+1] != lp);
        mk_s = mk;
        for (int i = 0; i < WIN; i++) begin
            if (hit_b8 && (i >= T - 7))
                mk_s[i] = 1'b0;
            if ((hit_h0 || hit_hb) && (i >= T - HLEN + 1))
                mk_s[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mk     <= '0;
            pl     <= '0;
            lp     <= 1'b0;
            out_d  <= 1'b0;
            out_cv <= 1'b0;
        end else if (stb) begin
            mk     <= {mk_s[T-1:0], in_mark};
            pl     <= {pl[T-1:0], in_pol};
            out_d  <= mk_s[T];
            out_cv <= mk_s[T] && (pl[T] == lp);
            if (hit_hb)
                lp <= ~lp;
            else if (mk_s[T])
                lp <= pl[T];
        end
    end

endmodule

// File: rtl/rxf_out_fsm.sv
module rxf_out_fsm
    import rxf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_stb,
    input  logic             pd_in,
    input  logic [FMT_W-1:0] fmt_in,
    input  logic             inv_in,
    input  logic             los_in,
    input  logic             rclk_in,
    input  logic             raw_p,
    input  logic             raw_n,
    input  logic             dec_d,
    input  logic             dec_cv,
    input  logic             rail_p,
    input  logic             rail_n,
    output logic             rclk_out,
    output logic             rd_p_out,
    output logic             rd_n_out,
    output logic             los_out,
    output fsm_t             st,
    output logic [FMT_W-1:0] fmt_q,
    output logic             inv_q
);
    fsm_t             st_nx;
    logic [FMT_W-1:0] fmt_nx;
    logic             inv_nx;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (act_stb) st_nx = pd_in ? ST_OFF : ST_RUN;
            ST_RUN:  if (act_stb && pd_in) st_nx = ST_OFF;
            ST_OFF:  if (act_stb && !pd_in) st_nx = ST_RUN;
            default: st_nx = ST_IDLE;
        endcase
        fmt_nx = act_stb ? fmt_in : fmt_q;
        inv_nx = act_stb ? inv_in : inv_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            fmt_q <= FMT_AMI;
            inv_q <= 1'b0;
        end else begin
            st    <= st_nx;
            fmt_q <= fmt_nx;
            inv_q <= inv_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rclk_out <= 1'b0;
            rd_p_out <= 1'b0;
            rd_n_out <= 1'b0;
            los_out  <= 1'b0;
        end else if (st_nx != ST_RUN) begin
            rclk_out <= 1'b0;
            rd_p_out <= 1'b0;
            rd_n_out <= 1'b0;
            los_out  <= 1'b0;
        end else begin
            los_out <= los_in;
            if (fmt_nx == FMT_PASS) begin
                rclk_out <= raw_p ^ raw_n;
                rd_p_out <= raw_p ^ inv_nx;
                rd_n_out <= raw_n ^ inv_nx;
            end else begin
                rclk_out <= rclk_in;
                if (act_stb) begin
                    if (fmt_nx[1]) begin
                        rd_p_out <= rail_p ^ inv_nx;
                        rd_n_out <= rail_n ^ inv_nx;
                    end else begin
                        rd_p_out <= dec_d ^ inv_nx;
                        rd_n_out <= dec_cv;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rx_line_formatter.sv
module rx_line_formatter
    import rxf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rclk_in,
    input  logic             pos_in,
    input  logic             neg_in,
    input  logic             los_in,
    input  logic [FMT_W-1:0] fmt_in,
    input  logic             e1_sel,
    input  logic             edge_sel,
    input  logic             inv_in,
    input  logic             pd_in,
    output logic             rclk_out,
    output logic             rd_p_out,
    output logic             rd_n_out,
    output logic             los_out
);
    logic             rise_stb;
    logic             act_stb;
    logic             rail_p;
    logic             rail_n;
    logic             dec_d;
    logic             dec_cv;
    fsm_t             st;
    logic [FMT_W-1:0] fmt_q;
    logic             inv_q;

    rxf_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .rclk_in  (rclk_in),
        .pos_in   (pos_in),
        .neg_in   (neg_in),
        .edge_sel (edge_sel),
        .rise_stb (rise_stb),
        .act_stb  (act_stb),
        .rail_p   (rail_p),
        .rail_n   (rail_n)
    );

    rxf_decoder #(.WIN(DEC_WIN), .HLEN(HDB_LEN)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (rise_stb),
        .in_mark (pos_in ^ neg_in),
        .in_pol  (pos_in),
        .sub_en  (fmt_q == FMT_SUB),
        .e1_mode (e1_sel),
        .out_d   (dec_d),
        .out_cv  (dec_cv)
    );

    rxf_out_fsm u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_stb  (act_stb),
        .pd_in    (pd_in),
        .fmt_in   (fmt_in),
        .inv_in   (inv_in),
        .los_in   (los_in),
        .rclk_in  (rclk_in),
        .raw_p    (pos_in),
        .raw_n    (neg_in),
        .dec_d    (dec_d),
        .dec_cv   (dec_cv),
        .rail_p   (rail_p),
        .rail_n   (rail_n),
        .rclk_out (rclk_out),
        .rd_p_out (rd_p_out),
        .rd_n_out (rd_n_out),
        .los_out  (los_out),
        .st       (st),
        .fmt_q    (fmt_q),
        .inv_q    (inv_q)
    );

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker
    import rxf_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             act_stb,
    input logic             pd_in,
    input logic             pos_in,
    input logic             neg_in,
    input fsm_t             st,
    input logic [FMT_W-1:0] fmt_q,
    input logic             inv_q,
    input logic             rclk_out,
    input logic             rd_p_out,
    input logic             rd_n_out,
    input logic             los_out
);
    assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (!rclk_out && !rd_p_out && !rd_n_out && !los_out));

    assert_hold_between_edges_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && !act_stb && fmt_q != FMT_PASS)
        |=> ($stable(rd_p_out) && $stable(rd_n_out)));

    assert_flag_on_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && !fmt_q[1] && rd_n_out) |-> (rd_p_out != inv_q));

    assert_pass_xor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && fmt_q == FMT_PASS && !act_stb)
        |=> (rclk_out == ($past(pos_in) ^ $past(neg_in))));

    assert_pd_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (act_stb && pd_in) |=> (!rclk_out && !rd_p_out && !rd_n_out && !los_out));

endmodule

bind rx_line_formatter rxf_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_stb  (act_stb),
    .pd_in    (pd_in),
    .pos_in   (pos_in),
    .neg_in   (neg_in),
    .st       (st),
    .fmt_q    (fmt_q),
    .inv_q    (inv_q),
    .rclk_out (rclk_out),
    .rd_p_out (rd_p_out),
    .rd_n_out (rd_n_out),
    .los_out  (los_out)
);

// File: tb/rx_line_formatter_tb.sv
module rx_line_formatter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rclk_in = 1'b0, pos_in = 1'b0, neg_in = 1'b0, los_in = 1'b0;
    logic [1:0] fmt_in = 2'b00;
    logic       e1_sel = 1'b0, edge_sel = 1'b0, inv_in = 1'b0, pd_in = 1'b0;
    logic       rclk_out, rd_p_out, rd_n_out, los_out;

    int total = 0;
    int bad = 0;
    string cur_req = "R4";

    localparam int MAXS = 64;
    logic sm [MAXS];
    logic sp [MAXS];
    logic ref_d [MAXS];
    logic ref_cv [MAXS];
    int   nsym = 0;

    logic [1:0] expq [$];
    logic       mon_on = 1'b0;
    logic       prev_ck = 1'b0;

    always #2 clk = ~clk;

    rx_line_formatter dut_i (
        .clk(clk), .rst_n(rst_n), .rclk_in(rclk_in), .pos_in(pos_in),
        .neg_in(neg_in), .los_in(los_in), .fmt_in(fmt_in), .e1_sel(e1_sel),
        .edge_sel(edge_sel), .inv_in(inv_in), .pd_in(pd_in),
        .rclk_out(rclk_out), .rd_p_out(rd_p_out), .rd_n_out(rd_n_out),
        .los_out(los_out)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        mon_on = 1'b0;
        rclk_in = 1'b0; pos_in = 1'b0; neg_in = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        prev_ck = 1'b0;
    endtask

    // stream building: mark/polarity
    task automatic clr_stream();
        for (int i = 0; i < MAXS; i++) begin sm[i] = 1'b0; sp[i] = 1'b0; end
        nsym = 0;
    endtask
    task automatic put(input int s); // +1, -1, 0
        sm[nsym] = (s != 0);
        sp[nsym] = (s > 0);
        nsym++;
    endtask

    // reference decoding from R5-R7
    task automatic ref_decode(input logic sub, input logic e1);
        logic m [MAXS];
        logic lp;
        lp = 1'b0;
        for (int i = 0; i < MAXS; i++) m[i] = sm[i];
        for (int i = 0; i < MAXS; i++) begin
            logic hb;
            hb = 1'b0;
            if (sub && !e1 && i + 7 < MAXS && !m[i] && !m[i+1] && !m[i+2]
                && m[i+3] && sp[i+3] == lp && m[i+4] && sp[i+4] != lp
                && !m[i+5] && m[i+6] && sp[i+6] != lp && m[i+7] && sp[i+7] == lp)
                for (int j = 0; j < 8; j++) m[i+j] = 1'b0;
            if (sub && e1 && i + 3 < MAXS) begin
                if (!m[i] && !m[i+1] && !m[i+2] && m[i+3] && sp[i+3] == lp)
                    for (int j = 0; j < 4; j++) m[i+j] = 1'b0;
                else if (m[i] && sp[i] != lp && !m[i+1] && !m[i+2]
                         && m[i+3] && sp[i+3] != lp) begin
                    for (int j = 0; j < 4; j++) m[i+j] = 1'b0;
                    hb = 1'b1;
                end
            end
            ref_d[i]  = m[i];
            ref_cv[i] = m[i] && (sp[i] == lp);
            if (hb) lp = ~lp;
            else if (m[i]) lp = sp[i];
        end
    endtask

    function automatic logic [1:0] expect_at(input int k, input logic rise);
        int idx;
        logic p, n;
        if (fmt_in[1]) begin
            idx = rise ? k - 1 : k;
            p = (idx >= 0) ? (sp[idx] & sm[idx]) : 1'b0;
            n = (idx >= 0) ? (~sp[idx] & sm[idx]) : 1'b0;
            return {p ^ inv_in, n ^ inv_in};
        end
        idx = rise ? k - 9 : k - 8;
        p = (idx >= 0) ? ref_d[idx] : 1'b0;
        n = (idx >= 0) ? ref_cv[idx] : 1'b0;
        return {p ^ inv_in, n};
    endfunction

    // driver: one recovered-clock period per symbol, expectations pushed per active edge
    task automatic run_stream(input int extra);
        mon_on = 1'b1;
        for (int k = 0; k < nsym + extra; k++) begin
            @(negedge clk);
            rclk_in = 1'b1;
            pos_in = sm[k] & sp[k];
            neg_in = sm[k] & ~sp[k];
            if (!edge_sel) expq.push_back(expect_at(k, 1'b1));
            repeat (4) @(negedge clk);
            rclk_in = 1'b0;
            if (edge_sel && k != 0) expq.push_back(expect_at(k, 1'b0));
            repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk({cur_req, " queue drained"}, expq.size() == 0, 1'b1);
        mon_on = 1'b0;
        expq.delete();
    endtask

    // monitor: at each visible active edge of rclk_out, pop and compare
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            if ((!edge_sel && !prev_ck && rclk_out) || (edge_sel && prev_ck && !rclk_out)) begin
                logic [1:0] e;
                if (expq.size() == 0) begin
                    total++; bad++;
                    $display("FAIL %s actual=edge expected=no-edge", cur_req);
                end else begin
                    e = expq.pop_front();
                    chk({cur_req, " rd_p"}, rd_p_out, e[1]);
                    chk({cur_req, " rd_n"}, rd_n_out, e[0]);
                end
            end
        end
        prev_ck = rclk_out;
    end

    task automatic pulse_rise(input logic p, input logic n);
        @(negedge clk); rclk_in = 1'b1; pos_in = p; neg_in = n;
        repeat (4) @(negedge clk); rclk_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 rclk_out", rclk_out, 1'b0);
        chk("R1 rd_p", rd_p_out, 1'b0);
        chk("R1 rd_n", rd_n_out, 1'b0);
        los_in = 1'b1; repeat (3) @(negedge clk);
        chk("R1 los_out before first edge", los_out, 1'b0);
        los_in = 1'b0;

        // R4 R5 R2: AMI single rail, rising active edge, with violations
        clr_stream();
        put(1); put(0); put(-1); put(1); put(1); put(0); put(-1); put(-1);
        put(1); put(0); put(0); put(-1); put(1); put(-1); put(-1); put(1);
        fmt_in = 2'b00; edge_sel = 1'b0; inv_in = 1'b0; e1_sel = 1'b0;
        ref_decode(1'b0, 1'b0);
        cur_req = "R4 R5 R2";
        do_reset();
        run_stream(12);

        // R6 R2: B8ZS on T1, falling active edge
        clr_stream();
        put(1); put(0); put(0); put(0); put(1); put(-1); put(0); put(-1); put(1);
        put(-1); put(0); put(1); put(0); put(0); put(0); put(-1); put(1); put(0);
        put(1); put(-1); put(1); put(1);
        fmt_in = 2'b01; edge_sel = 1'b1; e1_sel = 1'b0;
        ref_decode(1'b1, 1'b0);
        chk("R6 reference gives zeros", ref_d[4] | ref_d[7] | ref_d[8], 1'b0);
        cur_req = "R6 R2";
        do_reset();
        run_stream(12);

        // R7 R10: HDB3 on E1 with inversion
        clr_stream();
        put(1); put(0); put(0); put(0); put(1); put(-1); put(1); put(0); put(0);
        put(1); put(-1); put(0); put(1); put(-1); put(-1); put(0); put(0); put(-1);
        put(1);
        fmt_in = 2'b01; edge_sel = 1'b0; e1_sel = 1'b1; inv_in = 1'b1;
        ref_decode(1'b1, 1'b1);
        chk("R7 reference gives zeros", ref_d[4] | ref_d[6] | ref_d[9], 1'b0);
        cur_req = "R7 R10";
        do_reset();
        run_stream(12);

        // R8 R2: dual rail, falling edge
        clr_stream();
        put(1); put(-1); put(0); put(1); put(1); put(-1); put(0); put(0); put(-1); put(1);
        fmt_in = 2'b10; edge_sel = 1'b1; inv_in = 1'b0;
        cur_req = "R8 R2";
        do_reset();
        run_stream(3);

        // R3 R9 R10: format change deferred, then raw pass-through
        fmt_in = 2'b10; edge_sel = 1'b0; inv_in = 1'b0;
        do_reset();
        pulse_rise(1'b0, 1'b1);
        pulse_rise(1'b0, 1'b0);
        fmt_in = 2'b11; inv_in = 1'b1;
        pos_in = 1'b1; neg_in = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 format not yet applied rd_p", rd_p_out, 1'b0);
        chk("R3 format not yet applied rclk", rclk_out, 1'b0);
        pulse_rise(1'b1, 1'b0);
        pos_in = 1'b1; neg_in = 1'b0; @(negedge clk); @(negedge clk);
        chk("R9 rclk xor 10", rclk_out, 1'b1);
        chk("R9 R10 rd_p inverted", rd_p_out, 1'b0);
        chk("R9 R10 rd_n inverted", rd_n_out, 1'b1);
        pos_in = 1'b1; neg_in = 1'b1; @(negedge clk); @(negedge clk);
        chk("R9 rclk xor 11", rclk_out, 1'b0);
        pos_in = 1'b0; neg_in = 1'b1; @(negedge clk);
        chk("R9 one-cycle latency rclk", rclk_out, 1'b1);
        chk("R9 one-cycle latency rd_n", rd_n_out, 1'b0);

        // R11 R12: power-down and loss-of-signal
        fmt_in = 2'b10; inv_in = 1'b0; edge_sel = 1'b0; pd_in = 1'b0;
        do_reset();
        los_in = 1'b1;
        pulse_rise(1'b1, 1'b0);
        pulse_rise(1'b0, 1'b1);
        chk("R12 los follows", los_out, 1'b1);
        los_in = 1'b0; @(negedge clk); @(negedge clk);
        chk("R12 los clears", los_out, 1'b0);
        los_in = 1'b1; pd_in = 1'b1;
        @(negedge clk); rclk_in = 1'b1; pos_in = 1'b1; neg_in = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R11 rclk low", rclk_out, 1'b0);
        chk("R11 los low", los_out, 1'b0);
        chk("R11 rd_n low", rd_n_out, 1'b0);
        rclk_in = 1'b0; repeat (4) @(negedge clk);
        pulse_rise(1'b1, 1'b0);
        chk("R11 stays off", rd_p_out | rclk_out, 1'b0);
        pd_in = 1'b0;
        @(negedge clk); rclk_in = 1'b1; pos_in = 1'b0; neg_in = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R11 resumes rclk", rclk_out, 1'b1);
        chk("R11 resumes rd_p previous symbol", rd_p_out, 1'b1);
        chk("R11 R12 resumes los", los_out, 1'b1);
        rclk_in = 1'b0; repeat (3) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule